// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block holds a 256-entry colour table, each entry an 8-bit red, green and blue triple. Software programs it through a 16-byte register window of 32-bit words. One word selects which entry is written next. A second word takes colour bytes in a fixed red, green, blue order. A hidden sequencer tracks which component the next byte fills. After the third byte it moves the pointer to the following entry, so a full table loads as one index write followed by a stream of 768 data writes.

Display logic reads the table through a combinational lookup port addressed by an 8-bit pixel code. A one-cycle update strobe carries the index of each entry that a data write touched, so that downstream copies can be refreshed. Bus reads of the window always return zero. Writes finish in one cycle and never stall.

The sequencer has three named states: `PH_RED`, `PH_GREEN` and `PH_BLUE`. Its transitions are:
- `ADVANCE_G`: an accepted data write moves `PH_RED` to `PH_GREEN`.
- `ADVANCE_B`: an accepted data write moves `PH_GREEN` to `PH_BLUE`.
- `WRAP`: an accepted data write moves `PH_BLUE` to `PH_RED` and increments the pointer.
- `RELOAD`: an accepted index write moves any state to `PH_RED`.

Top module: `clut_loader`

## Requirements
- R1: After reset, entries 0 to 254 read as 0x000000 on the lookup port and entry 255 reads as 0xFFFFFF. The pointer is 0, the sequencer is in `PH_RED`, and `upd_valid` is low.
- R2: An accepted write to byte offset 0 loads the pointer from `wr_data[31:23+1]` (bits 31 to 24) and returns the sequencer to `PH_RED`.
- R3: An accepted write to byte offset 4 stores `wr_data[31:24]` into the current entry. The target component is red in `PH_RED`, green in `PH_GREEN` and blue in `PH_BLUE`. The lookup port packs an entry as {red[23:16], green[15:8], blue[7:0]}.
- R4: The data write made in `PH_BLUE` increments the pointer modulo 256, so 255 becomes 0, and returns the sequencer to `PH_RED`.
- R5: A write to any offset other than 0 or 4 leaves the table, the pointer and the sequencer unchanged and raises no strobe. This includes offsets 8 and 12 and any offset with a nonzero low two bits.
- R6: A write whose byte enables `wr_be` are not all ones is ignored in the same way, because only full 32-bit accesses count.
- R7: In the cycle after each accepted data write, `upd_valid` is high for exactly one cycle and `upd_idx` carries the entry written. In every other cycle `upd_valid` is low.
- R8: The lookup port is combinational. In the cycle in which a data write targets the looked-up entry, the port still shows the entry's old value. From the next cycle it shows the new value.
- R9: `bus_rd_data` is zero at all times.
- R10: An index write made part-way through a colour triple abandons that triple. Components already stored in the old entry are kept, and the next data write fills red of the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request, accepted in the same cycle |
| wr_addr | input | 4 | Byte offset within the register window |
| wr_be | input | 4 | Byte enables; all four must be set |
| wr_data | input | 32 | Write data; payload in bits 31:24 |
| bus_rd_data | output | 32 | Read data for the window, always zero |
| pix_idx | input | 8 | Lookup index from display logic |
| pix_rgb | output | 24 | Looked-up colour {red, green, blue} |
| upd_valid | output | 1 | One-cycle entry-updated strobe |
| upd_idx | output | 8 | Entry index accompanying the strobe |

## Verification
The embedded assertions check the following on every cycle:
- a data write lands in the component chosen by the sequencer state;
- the blue write wraps the sequencer and increments the pointer;
- an index write reloads the pointer and sequencer;
- the strobe follows each data write by exactly one cycle;
- rejected writes leave the pointer and state unchanged.

Some behaviours only the bench scenarios can show, because they span the whole table or compare against values computed independently. These are the reset colour of all 256 entries, the old-value-on-write behaviour of the lookup port, the wrap from entry 255 to entry 0, triples abandoned by an index reload, and the zero read data.

// File: rtl/clut_pkg.sv
package clut_pkg;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [7:0] red;
        logic [7:0] green;
        logic [7:0] blue;
    } rgb_t;

endpackage

// File: rtl/clut_decode.sv
module clut_decode #(
    parameter int ADDR_W  = 4,
    parameter int BE_W    = 4,
    parameter int IDX_OFF = 0,
    parameter int COL_OFF = 4
) (
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BE_W-1:0]   wr_be,
    output logic              idx_wr,
    output logic              col_wr
);
    localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(IDX_OFF);
    localparam logic [ADDR_W-1:0] COL_A = ADDR_W'(COL_OFF);

    logic full_word;

    always_comb begin
        full_word = &wr_be;
        idx_wr    = wr_valid && full_word && (wr_addr == IDX_A);
        col_wr    = wr_valid && full_word && (wr_addr == COL_A);
    end

endmodule

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic             col_wr,
    input  logic [7:0]       wr_byte,
    output logic [IDX_W-1:0] cur_idx,
    output phase_e           cur_phase,
    output logic             st_en,
    output logic [IDX_W-1:0] st_idx,
    output phase_e           st_sel,
    output logic             upd_valid,
    output logic [IDX_W-1:0] upd_idx
);
    phase_e           phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_RED;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
        end
    end

    // Next-state logic
    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        if (idx_wr) begin
            idx_d   = IDX_W'(wr_byte);
            phase_d = PH_RED;
        end else if (col_wr) begin
            unique case (phase_q)
                PH_RED:   phase_d = PH_GREEN;
                PH_GREEN: phase_d = PH_BLUE;
                PH_BLUE: begin
                    phase_d = PH_RED;
                    idx_d   = idx_q + 1'b1;
                end
                default:  phase_d = PH_RED;
            endcase
        end
    end

    // Output logic
    always_comb begin
        st_en     = col_wr;
        st_idx    = idx_q;
        st_sel    = phase_q;
        cur_idx   = idx_q;
        cur_phase = phase_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_idx   <= '0;
        end else begin
            upd_valid <= col_wr;
            if (col_wr) upd_idx <= idx_q;
        end
    end

    assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (idx_q == $past(IDX_W'(wr_byte)) && phase_q == PH_RED));

    assert_blue_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_wr && !idx_wr && phase_q == PH_BLUE) |=>
            (idx_q == $past(idx_q) + 1'b1 && phase_q == PH_RED));

    assert_red_to_green_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (col_wr && phase_q == PH_RED) |=> (phase_q == PH_GREEN && $stable(idx_q)));

    assert_strobe_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        col_wr |=> (upd_valid && upd_idx == $past(idx_q)));

    assert_strobe_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !col_wr |=> !upd_valid);

endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  phase_e           w_sel,
    input  logic [7:0]       w_byte,
    input  logic [IDX_W-1:0] r_idx,
    output rgb_t             r_rgb
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam rgb_t WHITE = '{red: 8'hFF, green: 8'hFF, blue: 8'hFF};

    rgb_t tbl [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++)
                tbl[i] <= (i == ENTRIES - 1) ? WHITE : '0;
        end else if (we) begin
            unique case (w_sel)
                PH_RED:   tbl[w_idx].red   <= w_byte;
                PH_GREEN: tbl[w_idx].green <= w_byte;
                PH_BLUE:  tbl[w_idx].blue  <= w_byte;
                default:  ;
            endcase
        end
    end

    // Combinational lookup: a same-cycle write shows up only after the edge
    assign r_rgb = tbl[r_idx];

    assert_red_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && w_sel == PH_RED) |=> tbl[$past(w_idx)].red == $past(w_byte));

    assert_green_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && w_sel == PH_GREEN) |=> tbl[$past(w_idx)].green == $past(w_byte));

    assert_blue_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && w_sel == PH_BLUE) |=> tbl[$past(w_idx)].blue == $past(w_byte));

endmodule

// File: rtl/clut_loader.sv
module clut_loader
    import clut_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] bus_rd_data,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [23:0]       pix_rgb,
    output logic              upd_valid,
    output logic [IDX_W-1:0]  upd_idx
);
    localparam int BE_W = DATA_W / 8;

    logic             idx_wr, col_wr, st_en;
    logic [7:0]       wr_byte;
    logic [IDX_W-1:0] cur_idx, st_idx;
    phase_e           cur_phase, st_sel;
    rgb_t             lut_out;
    logic             unused_low_data;

    assign wr_byte         = wr_data[DATA_W-1 -: 8];
    assign unused_low_data = ^wr_data[DATA_W-9:0];
    assign bus_rd_data     = '0;
    assign pix_rgb         = lut_out;

    clut_decode #(
        .ADDR_W (ADDR_W),
        .BE_W   (BE_W),
        .IDX_OFF(0),
        .COL_OFF(4)
    ) u_decode (
        .wr_valid(wr_valid),
        .wr_addr (wr_addr),
        .wr_be   (wr_be),
        .idx_wr  (idx_wr),
        .col_wr  (col_wr)
    );

    clut_seq #(.IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .col_wr   (col_wr),
        .wr_byte  (wr_byte),
        .cur_idx  (cur_idx),
        .cur_phase(cur_phase),
        .st_en    (st_en),
        .st_idx   (st_idx),
        .st_sel   (st_sel),
        .upd_valid(upd_valid),
        .upd_idx  (upd_idx)
    );

    clut_store #(.IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_en),
        .w_idx (st_idx),
        .w_sel (st_sel),
        .w_byte(wr_byte),
        .r_idx (pix_idx),
        .r_rgb (lut_out)
    );

    assert_rejected_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !idx_wr && !col_wr) |=>
            ($stable(cur_idx) && $stable(cur_phase) && !upd_valid));

    assert_partial_be_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !(&wr_be)) |=> ($stable(cur_idx) && $stable(cur_phase)));

endmodule

// File: tb/tb_clut_loader.sv
`timescale 1ns/1ps
module tb_clut_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] bus_rd_data;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;
    logic        upd_valid;
    logic [7:0]  upd_idx;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    logic [23:0] m_tbl [256];
    logic [7:0]  m_idx;
    int          m_ph;

    always #4 clk = ~clk;

    clut_loader dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(wr_data), .bus_rd_data(bus_rd_data),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb), .upd_valid(upd_valid),
        .upd_idx(upd_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] put_comp(input logic [23:0] e, input int ph, input logic [7:0] b);
        logic [23:0] r = e;
        case (ph)
            0: r[23:16] = b;
            1: r[15:8]  = b;
            default: r[7:0] = b;
        endcase
        return r;
    endfunction

    function automatic bit accepted(input logic [3:0] a, input logic [3:0] be);
        return (be == 4'hF) && (a == 4'd0 || a == 4'd4);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) m_tbl[i] = (i == 255) ? 24'hFFFFFF : 24'h0;
        m_idx = 8'd0;
        m_ph  = 0;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        bit is_col, acc;
        logic [7:0] tgt;
        acc    = accepted(a, be);
        is_col = acc && (a == 4'd4);
        tgt    = m_idx;
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
        pix_idx = tgt;
        #1;
        if (is_col) chk("R8 old value during write", {8'h0, pix_rgb}, {8'h0, m_tbl[tgt]});
        if (is_col) begin
            m_tbl[tgt] = put_comp(m_tbl[tgt], m_ph, d[31:24]);
            if (m_ph == 2) begin m_ph = 0; m_idx = m_idx + 8'd1; end
            else m_ph = m_ph + 1;
        end else if (acc) begin
            m_idx = d[31:24];
            m_ph  = 0;
        end
        @(negedge clk);
        wr_valid = 1'b0;
        if (!acc) begin
            chk((be != 4'hF) ? "R6 strobe after partial write" : "R5 strobe after other offset",
                {31'h0, upd_valid}, 32'h0);
        end else begin
            chk("R7 strobe", {31'h0, upd_valid}, {31'h0, is_col});
        end
        if (is_col) begin
            chk("R7 strobe index", {24'h0, upd_idx}, {24'h0, tgt});
            pix_idx = tgt; #1;
            chk("R3 stored component", {8'h0, pix_rgb}, {8'h0, m_tbl[tgt]});
        end else begin
            pix_idx = m_idx; #1;
            chk(acc ? "R2 entry at pointer" : "R5 R6 entry unchanged", {8'h0, pix_rgb}, {8'h0, m_tbl[m_idx]});
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents and idle strobe
        chk("R1 strobe idle", {31'h0, upd_valid}, 32'h0);
        for (int i = 0; i < 256; i++) begin
            pix_idx = 8'(i); #1;
            chk("R1 reset colour", {8'h0, pix_rgb}, {8'h0, m_tbl[i]});
        end
        chk("R9 read zero", bus_rd_data, 32'h0);

        // R1 pointer starts at 0 in red phase
        do_write(4'd4, 4'hF, 32'h11_000000);
        do_write(4'd4, 4'hF, 32'h22_000000);
        do_write(4'd4, 4'hF, 32'h33_000000);
        pix_idx = 8'd0; #1;
        chk("R1 R3 triple at entry 0", {8'h0, pix_rgb}, 32'h00112233);

        // R2 + R4: wrap from 255
        do_write(4'd0, 4'hF, 32'hFF_ABCDEF);
        do_write(4'd4, 4'hF, 32'h01_000000);
        do_write(4'd4, 4'hF, 32'h02_000000);
        do_write(4'd4, 4'hF, 32'h03_000000);
        do_write(4'd4, 4'hF, 32'h44_000000);
        chk("R4 wrap to entry 0", {24'h0, upd_idx}, 32'h0);

        // R10: abandon mid-triple
        do_write(4'd0, 4'hF, 32'h05_000000);
        do_write(4'd4, 4'hF, 32'h55_000000);
        do_write(4'd4, 4'hF, 32'h66_000000);
        do_write(4'd0, 4'hF, 32'h09_000000);
        do_write(4'd4, 4'hF, 32'h99_000000);
        pix_idx = 8'd5; #1;
        chk("R10 old entry kept", {8'h0, pix_rgb}, 32'h00556600);
        pix_idx = 8'd9; #1;
        chk("R10 red of new entry", {8'h0, pix_rgb}, 32'h00990000);

        // R5 / R6 directed
        do_write(4'd8,  4'hF, 32'hDE_000000);
        do_write(4'd12, 4'hF, 32'hAD_000000);
        do_write(4'd5,  4'hF, 32'hBE_000000);
        do_write(4'd4,  4'h8, 32'hEF_000000);
        do_write(4'd0,  4'h7, 32'h77_000000);
        do_write(4'd4,  4'hF, 32'h12_000000);
        chk("R5 R6 pointer unmoved", {24'h0, upd_idx}, 32'h9);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int sel;
            logic [3:0] a, be;
            sel = $urandom % 10;
            a   = (sel < 5) ? 4'd4 : (sel < 7) ? 4'd0 : 4'($urandom);
            be  = ($urandom % 10 == 0) ? 4'($urandom) : 4'hF;
            do_write(a, be, $urandom);
            if (n % 50 == 0) chk("R9 read zero", bus_rd_data, 32'h0);
        end

        // Final sweep against model
        for (int i = 0; i < 256; i++) begin
            pix_idx = 8'(i); #1;
            chk("R3 final table", {8'h0, pix_rgb}, {8'h0, m_tbl[i]});
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule